// File: doc/BRIEF.md
# Interleaved Coarse-Fine Code Combiner

This block builds full-resolution samples for an interleaved converter. A full-rate coarse quantizer supplies a 4-bit estimate with every sample. Eight slower fine channels each convert one sample in eight and return a 7-bit residue. The residue carries one bit of redundancy, so the two parts overlap. The block adds them with an offset instead of joining the bits. It then clamps the sum into a 10-bit word.

Each coarse estimate is kept in a holding register for the channel that converts the same sample. When that channel's residue strobe arrives, the block combines the held estimate with the residue. The finished word waits in a per-channel slot until its turn. Words leave in the original sample order, one per clock. An out-of-window flag goes with each word. Every raw residue is also passed out, registered, for a downstream skew-calibration engine.

Top module: `coarse_fine_combiner`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_vld`, `out_word`, `out_ovr` and all `cal_vld` bits are cleared. The first coarse strobe after reset belongs to channel 0, and the first word emitted comes from channel 0.
- R2: The k-th coarse strobe after reset, counting from 0, belongs to channel k mod 8. Every strobed sample whose residue arrives produces exactly one output word.
- R3: The output word equals coarse×64 + residue − 32 whenever that value lies within 0 to 1023.
- R4: A combined value below 0 is output as 0, and a combined value above 1023 is output as 1023.
- R5: `out_ovr` is 1 with a word exactly when that word's residue is below 32 or above 95.
- R6: Words leave in strict channel order 0, 1, …, 7, 0, …, which is sample order. This holds even when channels complete their residues out of order, provided each residue arrives between 1 and 8 cycles after its coarse strobe.
- R7: With a constant residue latency and back-to-back coarse strobes, `out_vld` stays high for one word per clock without gaps once the first word appears.
- R8: One clock after `fine_vld[c]` is high, `cal_vld[c]` is high and `cal_code[c*7 +: 7]` holds the residue that was presented. In other cycles `cal_vld[c]` is low.
- R9: `coarse_code` is ignored in cycles where `coarse_vld` is low. Such cycles neither advance the channel assignment nor alter any held estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coarse_vld | input | 1 | Coarse estimate present this cycle |
| coarse_code | input | 4 | Coarse estimate of the current sample |
| fine_vld | input | 8 | Per-channel residue strobe |
| fine_code | input | 56 | Per-channel residues, channel c at bits c*7 +: 7 |
| out_vld | output | 1 | Output word valid |
| out_word | output | 10 | Combined, clamped sample in sample order |
| out_ovr | output | 1 | Residue of this word lay outside 32..95 |
| cal_vld | output | 8 | Registered residue strobe per channel |
| cal_code | output | 56 | Registered raw residue per channel |

## Verification
Three stimulus sets are compared with a behavioural queue model on every clock. The first uses mid-range residues with a fixed latency and dense strobes. It separates correct offset arithmetic from plain concatenation and shows whether the output stream runs without gaps. The second pairs extreme coarse codes with out-of-window residues and makes later-sampled channels finish first. It exposes missing saturation, a wrong out-of-window flag and any release that follows completion order instead of sample order. The third uses random codes, random latencies and idle gaps carrying junk coarse values. It shows whether idle cycles disturb the channel assignment or the held estimates.

// File: rtl/cfc_pkg.sv
// Shared sizing for the coarse-fine combiner.
// Assumes: the channel count is at least 2.
package cfc_pkg;
    localparam int CFC_N_CH     = 8;
    localparam int CFC_COARSE_W = 4;
    localparam int CFC_FINE_W   = 7;
    localparam int CFC_OUT_W    = 10;
endpackage

// File: rtl/cfc_coarse_hold.sv
// Assigns each strobed coarse estimate to the next channel in round-robin order
// and keeps it until that channel's residue is merged.
// Assumes: a channel's residue arrives before its next coarse strobe overwrites the estimate.
module cfc_coarse_hold #(
    parameter int N_CH     = cfc_pkg::CFC_N_CH,
    parameter int COARSE_W = cfc_pkg::CFC_COARSE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     coarse_vld,
    input  logic [COARSE_W-1:0]      coarse_code,
    output logic [N_CH*COARSE_W-1:0] hold_flat
);
    localparam int CH_W = $clog2(N_CH);

    logic [CH_W-1:0]     wr_ptr;
    logic [COARSE_W-1:0] hold_q [N_CH];

    // Purpose: step the channel pointer on each strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (coarse_vld)
            wr_ptr <= (wr_ptr == CH_W'(N_CH - 1)) ? '0 : wr_ptr + 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_hold
            // Purpose: capture the estimate for channel g when it is that channel's turn.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hold_q[g] <= '0;
                else if (coarse_vld && (wr_ptr == CH_W'(g)))
                    hold_q[g] <= coarse_code;
            end
            assign hold_flat[g*COARSE_W +: COARSE_W] = hold_q[g];
        end
    endgenerate

    p_ptr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !coarse_vld |=> $stable(wr_ptr));
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_vld |=> (wr_ptr != $past(wr_ptr)));
endmodule

// File: rtl/cfc_merge.sv
// Merges one held coarse estimate with one residue into a clamped output word
// and flags a residue that lies outside its nominal window. Purely combinational.
// Assumes: FINE_W >= 2; the redundancy bit gives an offset of a quarter of the residue range.
module cfc_merge #(
    parameter int COARSE_W = cfc_pkg::CFC_COARSE_W,
    parameter int FINE_W   = cfc_pkg::CFC_FINE_W,
    parameter int OUT_W    = cfc_pkg::CFC_OUT_W
) (
    input  logic [COARSE_W-1:0] coarse,
    input  logic [FINE_W-1:0]   fine,
    output logic [OUT_W-1:0]    word,
    output logic                ovr
);
    localparam int SHIFT  = FINE_W - 1;
    localparam int OFFSET = 1 << (FINE_W - 2);
    localparam int WIN_HI = OFFSET + (1 << SHIFT) - 1;
    localparam int MAXV   = (1 << OUT_W) - 1;
    localparam int SW     = COARSE_W + FINE_W + 1;

    logic signed [SW-1:0] sum;

    // Purpose: weighted add with offset, then clamp into the output range.
    always_comb begin
        sum = $signed({{(SW-COARSE_W-SHIFT){1'b0}}, coarse, {SHIFT{1'b0}}})
            + $signed({{(SW-FINE_W){1'b0}}, fine})
            - $signed(SW'(OFFSET));
        if (sum < 0)
            word = '0;
        else if (sum > $signed(SW'(MAXV)))
            word = OUT_W'(MAXV);
        else
            word = sum[OUT_W-1:0];
    end

    // Purpose: out-of-window detection on the raw residue.
    assign ovr = (fine < FINE_W'(OFFSET)) || (fine > FINE_W'(WIN_HI));
endmodule

// File: rtl/cfc_reorder.sv
// Parks each finished word in its channel slot and releases slots in strict
// round-robin channel order, one word per clock, through an output register.
// Assumes: a slot is released before the same channel writes it again.
module cfc_reorder #(
    parameter int N_CH  = cfc_pkg::CFC_N_CH,
    parameter int OUT_W = cfc_pkg::CFC_OUT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CH-1:0]       wr_en,
    input  logic [N_CH*OUT_W-1:0] wr_word,
    input  logic [N_CH-1:0]       wr_ovr,
    output logic                  out_vld,
    output logic [OUT_W-1:0]      out_word,
    output logic                  out_ovr
);
    localparam int CH_W = $clog2(N_CH);

    logic [OUT_W-1:0] slot_w [N_CH];
    logic [N_CH-1:0]  slot_o;
    logic [N_CH-1:0]  full;
    logic [CH_W-1:0]  rd_ptr;
    logic             take;
    logic [N_CH-1:0]  take_vec;

    // Purpose: release is possible when the slot under the pointer holds a word.
    assign take = full[rd_ptr];

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_slot
            assign take_vec[g] = take && (rd_ptr == CH_W'(g));
            // Purpose: store a new word and track occupancy; a write outranks a release.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    full[g]   <= 1'b0;
                    slot_w[g] <= '0;
                    slot_o[g] <= 1'b0;
                end else begin
                    full[g] <= wr_en[g] | (full[g] & ~take_vec[g]);
                    if (wr_en[g]) begin
                        slot_w[g] <= wr_word[g*OUT_W +: OUT_W];
                        slot_o[g] <= wr_ovr[g];
                    end
                end
            end
        end
    endgenerate

    // Purpose: output register and in-order pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            out_vld  <= 1'b0;
            out_word <= '0;
            out_ovr  <= 1'b0;
        end else begin
            out_vld <= take;
            if (take) begin
                out_word <= slot_w[rd_ptr];
                out_ovr  <= slot_o[rd_ptr];
                rd_ptr   <= (rd_ptr == CH_W'(N_CH - 1)) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_vld && rd_ptr == '0));
    p_order_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (rd_ptr != $past(rd_ptr)));
    p_order_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> $stable(rd_ptr));
    p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en & full & ~take_vec) == '0);
endmodule

// File: rtl/coarse_fine_combiner.sv
// Top level: holds coarse estimates per channel, merges them with the residues,
// restores sample order, and registers raw residues for calibration.
// Assumes: each residue arrives 1 to N_CH cycles after its coarse strobe.
module coarse_fine_combiner #(
    parameter int N_CH     = cfc_pkg::CFC_N_CH,
    parameter int COARSE_W = cfc_pkg::CFC_COARSE_W,
    parameter int FINE_W   = cfc_pkg::CFC_FINE_W,
    parameter int OUT_W    = cfc_pkg::CFC_OUT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   coarse_vld,
    input  logic [COARSE_W-1:0]    coarse_code,
    input  logic [N_CH-1:0]        fine_vld,
    input  logic [N_CH*FINE_W-1:0] fine_code,
    output logic                   out_vld,
    output logic [OUT_W-1:0]       out_word,
    output logic                   out_ovr,
    output logic [N_CH-1:0]        cal_vld,
    output logic [N_CH*FINE_W-1:0] cal_code
);
    logic [N_CH*COARSE_W-1:0] hold_flat;
    logic [N_CH*OUT_W-1:0]    merged;
    logic [N_CH-1:0]          merged_ovr;

    cfc_coarse_hold #(.N_CH(N_CH), .COARSE_W(COARSE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .coarse_vld(coarse_vld),
        .coarse_code(coarse_code), .hold_flat(hold_flat)
    );

    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_merge
            cfc_merge #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .OUT_W(OUT_W)) u_merge (
                .coarse(hold_flat[g*COARSE_W +: COARSE_W]),
                .fine(fine_code[g*FINE_W +: FINE_W]),
                .word(merged[g*OUT_W +: OUT_W]),
                .ovr(merged_ovr[g])
            );
        end
    endgenerate

    cfc_reorder #(.N_CH(N_CH), .OUT_W(OUT_W)) u_reorder (
        .clk(clk), .rst_n(rst_n), .wr_en(fine_vld), .wr_word(merged),
        .wr_ovr(merged_ovr), .out_vld(out_vld), .out_word(out_word), .out_ovr(out_ovr)
    );

    // Purpose: registered copy of raw residues and their strobes for calibration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_vld  <= '0;
            cal_code <= '0;
        end else begin
            cal_vld <= fine_vld;
            for (int c = 0; c < N_CH; c++)
                if (fine_vld[c])
                    cal_code[c*FINE_W +: FINE_W] <= fine_code[c*FINE_W +: FINE_W];
        end
    end

    p_cal_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        |fine_vld |=> |cal_vld);
endmodule

// File: tb/sim_coarse_fine_combiner.sv
module sim_coarse_fine_combiner;
    localparam int NCH = 8;
    localparam int FW  = 7;
    localparam int MAXS = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             coarse_vld = 1'b0;
    logic [3:0]       coarse_code = '0;
    logic [NCH-1:0]   fine_vld = '0;
    logic [NCH*FW-1:0] fine_code = '0;
    logic             out_vld;
    logic [9:0]       out_word;
    logic             out_ovr;
    logic [NCH-1:0]   cal_vld;
    logic [NCH*FW-1:0] cal_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0] cc [MAXS];
    logic [6:0] rr [MAXS];
    int st [MAXS];
    int lt [MAXS];
    int exp_w [$];
    bit exp_o [$];
    string exp_t [$];

    always #5 clk = ~clk;

    coarse_fine_combiner u0 (
        .clk(clk), .rst_n(rst_n), .coarse_vld(coarse_vld), .coarse_code(coarse_code),
        .fine_vld(fine_vld), .fine_code(fine_code), .out_vld(out_vld),
        .out_word(out_word), .out_ovr(out_ovr), .cal_vld(cal_vld), .cal_code(cal_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; coarse_vld = 1'b0; fine_vld = '0;
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
        chk(out_word == '0, "R1 out_word", int'(out_word), 0);
        chk(cal_vld == '0, "R1 cal_vld", int'(cal_vld), 0);
        rst_n = 1'b1;
    endtask

    // mode 0: dense, fixed latency, mid-window; 1: extremes, reversed latency; 2: random with gaps
    task automatic run_phase(input int mode, input int ns);
        int t = 0;
        int tend;
        int popped = 0;
        int first_c = -1;
        int last_c = -1;
        int vcount = 0;
        logic [NCH-1:0] prev_v = '0;
        logic [NCH*FW-1:0] prev_c = '0;
        exp_w.delete(); exp_o.delete(); exp_t.delete();
        for (int k = 0; k < ns; k++) begin
            st[k] = t;
            t += 1 + ((mode == 2 && ($urandom % 4 == 0)) ? 1 + int'($urandom % 2) : 0);
            case (mode)
                0: begin cc[k] = 4'(k % 16); rr[k] = 7'(32 + ($urandom % 64)); lt[k] = 5; end
                1: begin
                    lt[k] = 8 - (k % 8);
                    case (k % 4)
                        0: begin cc[k] = 4'd0;  rr[k] = 7'($urandom % 32); end
                        1: begin cc[k] = 4'd15; rr[k] = 7'(96 + ($urandom % 32)); end
                        2: begin cc[k] = 4'd15; rr[k] = 7'd95; end
                        default: begin cc[k] = 4'd0; rr[k] = 7'd32; end
                    endcase
                end
                default: begin cc[k] = 4'($urandom); rr[k] = 7'($urandom); lt[k] = 1 + int'($urandom % 8); end
            endcase
            begin
                int v = int'(cc[k]) * 64 + int'(rr[k]) - 32;
                bit sat = (v < 0) || (v > 1023);
                exp_w.push_back(v < 0 ? 0 : (v > 1023 ? 1023 : v));
                exp_o.push_back(rr[k] < 32 || rr[k] > 95);
                exp_t.push_back(sat ? "R4" : (mode == 0 ? "R3" : (mode == 1 ? "R6" : "R9")));
            end
        end
        tend = st[ns-1] + 8 + 12;
        for (int cyc = 0; cyc < tend; cyc++) begin
            // observe results of the previous edge
            if (out_vld) begin
                vcount++;
                if (first_c < 0) first_c = cyc;
                last_c = cyc;
                if (exp_w.size() == 0) begin
                    chk(1'b0, "R2 extra word", int'(out_word), -1);
                end else begin
                    int ew = exp_w.pop_front();
                    bit eo = exp_o.pop_front();
                    string et = exp_t.pop_front();
                    chk(int'(out_word) == ew, et, int'(out_word), ew);
                    chk(out_ovr == eo, "R5", int'(out_ovr), int'(eo));
                    popped++;
                end
            end
            for (int c = 0; c < NCH; c++) begin
                chk(cal_vld[c] == prev_v[c], "R8 cal_vld", int'(cal_vld[c]), int'(prev_v[c]));
                if (prev_v[c])
                    chk(cal_code[c*FW +: FW] == prev_c[c*FW +: FW], "R8 cal_code",
                        int'(cal_code[c*FW +: FW]), int'(prev_c[c*FW +: FW]));
            end
            // drive this cycle
            coarse_vld = 1'b0;
            coarse_code = 4'($urandom);
            fine_vld = '0;
            for (int k = 0; k < ns; k++) begin
                if (st[k] == cyc) begin
                    coarse_vld = 1'b1;
                    coarse_code = cc[k];
                end
                if (st[k] + lt[k] == cyc) begin
                    fine_vld[k % NCH] = 1'b1;
                    fine_code[(k % NCH)*FW +: FW] = rr[k];
                end
            end
            prev_v = fine_vld;
            prev_c = fine_code;
            @(negedge clk);
        end
        chk(popped == ns, "R2 word count", popped, ns);
        if (mode == 0) begin
            chk(vcount == ns, "R7 valid count", vcount, ns);
            chk(last_c - first_c + 1 == ns, "R7 gapless span", last_c - first_c + 1, ns);
        end
    endtask

    initial begin
        do_reset();
        run_phase(0, 64);
        do_reset();
        run_phase(1, 64);
        do_reset();
        run_phase(2, 120);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule